// File: doc/BRIEF.md
# Clock Reference Priority Selector

This block decides which timing reference steers the local oscillator of a central network-element clock. Six candidate inputs each report a health bit and a quality-level code. Two reference types each contribute a pair of ports, an active-controller side and a standby-controller side. The other two types contribute one port each. Software programs an ordered list of up to four reference types and a per-slot enable. The block expands that list into a ranked list of candidates. Each pair type takes two places in a row, with the active-side port ahead of the standby-side port.

Selection runs in one of three ways. In quality mode, the usable candidate with the highest quality code wins, and list position breaks ties. In revertive mode without quality selection, the block always takes the highest-ranked healthy candidate. In non-revertive mode, it stays on the current reference while that reference stays healthy. When no candidate is usable, the block enters holdover. A one-cycle event pulse marks every change of the active reference or of the holdover state.

Candidate numbering:
- 0 is the external timing port, active side.
- 1 is the external timing port, standby side.
- 2 is the first line reference.
- 3 is the second line reference.
- 4 is the packet/Ethernet timing port, active side.
- 5 is the packet/Ethernet timing port, standby side.

Type codes in the list are 0 external, 1 line reference one, 2 line reference two and 3 packet/Ethernet.

Top module: `clkref_selector`

## Requirements
- R1: The list slot at bits [2s+1:2s] of `prio_order` has rank s, and slot 0 is the highest priority. Only slots whose `prio_valid` bit is set count. Type 0 expands to candidates 0 then 1. Type 3 expands to candidates 4 then 5. Types 1 and 2 map to candidates 2 and 3. A type that appears twice keeps its first position. A candidate whose type is not in the enabled list is never selected.
- R2: With quality selection off and revertive mode on, the output is the healthy candidate with the best rank. This holds even when that candidate has just recovered.
- R3: With quality selection off and revertive mode off, the block keeps the current reference while it stays healthy. It moves to the best-ranked healthy candidate only when the current reference fails.
- R4: With quality selection on, the usable candidate with the numerically largest quality code wins, whatever the revertive setting. Ties go to the better rank. The code of candidate c sits at `cand_ql[c*QL_W +: QL_W]`.
- R5: With quality selection on, a quality code of 0 marks the candidate as unusable. With quality selection off, the quality codes have no effect.
- R6: When no candidate is usable, `holdover` is 1 and `active_idx` reads 7.
- R7: On leaving holdover, the block picks the best-ranked healthy candidate, or the best-quality one in quality mode, in either revertive mode.
- R8: `switch_evt` is high for exactly one cycle whenever `active_idx` or `holdover` changes, and low otherwise.
- R9: Reset gives `holdover`=1, `active_idx`=7 and `switch_evt`=0. An input change is visible on the outputs after the second rising clock edge that follows it, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_ok | input | 6 | Per-candidate health, 1 = ok |
| cand_ql | input | 6*QL_W | Per-candidate quality code, candidate c at [c*QL_W +: QL_W] |
| prio_order | input | 2*N_SLOTS | Ordered list of type codes, slot 0 in the low bits |
| prio_valid | input | N_SLOTS | Per-slot enable of the list |
| ql_sel_en | input | 1 | Quality-level selection enable |
| revertive_en | input | 1 | Revertive reselection enable |
| active_idx | output | 3 | Selected candidate, 7 in holdover |
| holdover | output | 1 | No usable candidate |
| switch_evt | output | 1 | One-cycle pulse on any change of selection |

## Verification
The bench targets three kinds of corner case:
- Pair expansion: a standby port must follow its active side ahead of the next type. A design that ranked whole types would pick the wrong port.
- Duplicate or disabled list slots: a design that counted them would shift every later rank.
- Quality ties: these must resolve by list position, not by candidate number. Code 0 must knock out an otherwise healthy candidate.

Directed runs also cover several timing and mode cases:
- A higher-priority reference recovers under non-revertive mode. A design that reverts there would produce a spurious switch event.
- A quality change arrives while the current reference is still healthy. A design that applied non-revertive stickiness in quality mode would fail to move.
- The output must not move after the first edge, which catches a one-stage or three-stage latency error.

// File: rtl/clkref_pkg.sv
package clkref_pkg;

   localparam int NUM_CAND = 6;
   localparam int CAND_W   = 3;
   localparam int RANK_W   = 3;
   localparam int TYPE_W   = 2;

   localparam logic [CAND_W-1:0] NO_REF = 3'd7;

   typedef enum logic [TYPE_W-1:0] {
      TYPE_EXT  = 2'd0,
      TYPE_LN1  = 2'd1,
      TYPE_LN2  = 2'd2,
      TYPE_PKT  = 2'd3
   } ref_type_e;

   // reference type that owns a candidate slot
   function automatic logic [TYPE_W-1:0] cand_type(input int c);
      case (c)
         0, 1:    return TYPE_EXT;
         2:       return TYPE_LN1;
         3:       return TYPE_LN2;
         default: return TYPE_PKT;
      endcase
   endfunction

   // 1 for the standby side of a paired type
   function automatic logic cand_sub(input int c);
      return (c == 1) || (c == 5);
   endfunction

   function automatic logic type_is_pair(input logic [TYPE_W-1:0] t);
      return (t == TYPE_EXT) || (t == TYPE_PKT);
   endfunction

endpackage

// File: rtl/clkref_rank_map.sv
module clkref_rank_map
   import clkref_pkg::*;
#(
   parameter int N_SLOTS = 4
) (
   input  logic [TYPE_W*N_SLOTS-1:0]            order_i,
   input  logic [N_SLOTS-1:0]                   slot_en_i,
   output logic [NUM_CAND-1:0][RANK_W-1:0]      rank_o,
   output logic [NUM_CAND-1:0]                  listed_o
);

   for (genvar c = 0; c < NUM_CAND; c++) begin : g_cand
      localparam logic [TYPE_W-1:0] CT  = cand_type(c);
      localparam logic              SUB = cand_sub(c);

      logic [RANK_W-1:0] pos;
      logic              hit;

      always_comb begin
         logic [RANK_W-1:0] acc;
         acc = '0;
         hit = 1'b0;
         pos = '0;
         for (int s = 0; s < N_SLOTS; s++) begin
            if (slot_en_i[s] && !hit) begin
               if (order_i[TYPE_W*s +: TYPE_W] == CT) begin
                  pos = acc + RANK_W'(SUB);
                  hit = 1'b1;
               end else begin
                  acc = acc + (type_is_pair(order_i[TYPE_W*s +: TYPE_W]) ?
                               RANK_W'(2) : RANK_W'(1));
               end
            end
         end
      end

      assign rank_o[c]   = pos;
      assign listed_o[c] = hit;
   end

endmodule

// File: rtl/clkref_best_pick.sv
module clkref_best_pick
   import clkref_pkg::*;
#(
   parameter int QL_W = 4
) (
   input  logic [NUM_CAND-1:0]                  usable_i,
   input  logic [NUM_CAND-1:0][QL_W-1:0]        ql_i,
   input  logic [NUM_CAND-1:0][RANK_W-1:0]      rank_i,
   output logic                                 any_o,
   output logic [CAND_W-1:0]                    best_o
);

   localparam int KEY_W = QL_W + RANK_W;

   // key: quality first, then inverted rank so that a better rank is larger
   always_comb begin
      logic [KEY_W-1:0] best_key;
      logic [KEY_W-1:0] key;
      any_o    = 1'b0;
      best_o   = NO_REF;
      best_key = '0;
      for (int c = 0; c < NUM_CAND; c++) begin
         key = {ql_i[c], ~rank_i[c]};
         if (usable_i[c] && (!any_o || key > best_key)) begin
            any_o    = 1'b1;
            best_o   = CAND_W'(c);
            best_key = key;
         end
      end
   end

endmodule

// File: rtl/clkref_selector.sv
module clkref_selector
   import clkref_pkg::*;
#(
   parameter int QL_W    = 4,
   parameter int N_SLOTS = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_CAND-1:0]         cand_ok,
   input  logic [NUM_CAND*QL_W-1:0]    cand_ql,
   input  logic [TYPE_W*N_SLOTS-1:0]   prio_order,
   input  logic [N_SLOTS-1:0]          prio_valid,
   input  logic                        ql_sel_en,
   input  logic                        revertive_en,
   output logic [CAND_W-1:0]           active_idx,
   output logic                        holdover,
   output logic                        switch_evt
);

   if (QL_W < 1 || QL_W > 8) begin : g_bad_ql
      $error("clkref_selector: QL_W must lie in 1..8");
   end
   if (N_SLOTS < 1 || N_SLOTS > 4) begin : g_bad_slots
      $error("clkref_selector: N_SLOTS must lie in 1..4");
   end

   // ---------------- input stage ----------------
   logic [NUM_CAND-1:0]               ok_q;
   logic [NUM_CAND-1:0][QL_W-1:0]     ql_q;
   logic [TYPE_W*N_SLOTS-1:0]         order_q;
   logic [N_SLOTS-1:0]                slot_en_q;
   logic                              ql_mode_q;
   logic                              revert_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ok_q      <= '0;
         ql_q      <= '0;
         order_q   <= '0;
         slot_en_q <= '0;
         ql_mode_q <= 1'b0;
         revert_q  <= 1'b0;
      end else begin
         ok_q      <= cand_ok;
         ql_q      <= cand_ql;
         order_q   <= prio_order;
         slot_en_q <= prio_valid;
         ql_mode_q <= ql_sel_en;
         revert_q  <= revertive_en;
      end
   end

   // ---------------- ranking ----------------
   logic [NUM_CAND-1:0][RANK_W-1:0]   rank;
   logic [NUM_CAND-1:0]               listed;

   clkref_rank_map #(.N_SLOTS(N_SLOTS)) u_rank (
      .order_i   (order_q),
      .slot_en_i (slot_en_q),
      .rank_o    (rank),
      .listed_o  (listed)
   );

   logic [NUM_CAND-1:0]               usable;
   logic [NUM_CAND-1:0][QL_W-1:0]     ql_eff;

   for (genvar c = 0; c < NUM_CAND; c++) begin : g_use
      assign usable[c] = ok_q[c] && listed[c] && (!ql_mode_q || (ql_q[c] != '0));
      assign ql_eff[c] = ql_mode_q ? ql_q[c] : '0;
   end

   logic              any_ok;
   logic [CAND_W-1:0] best;

   clkref_best_pick #(.QL_W(QL_W)) u_pick (
      .usable_i (usable),
      .ql_i     (ql_eff),
      .rank_i   (rank),
      .any_o    (any_ok),
      .best_o   (best)
   );

   // ---------------- selection state ----------------
   logic              cur_ok;
   logic [CAND_W-1:0] idx_nxt;
   logic              hold_nxt;

   assign cur_ok = !holdover && (active_idx < CAND_W'(NUM_CAND)) && usable[active_idx];

   always_comb begin
      if (!any_ok) begin
         idx_nxt  = NO_REF;
         hold_nxt = 1'b1;
      end else if (!ql_mode_q && !revert_q && cur_ok) begin
         idx_nxt  = active_idx;
         hold_nxt = 1'b0;
      end else begin
         idx_nxt  = best;
         hold_nxt = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_idx <= NO_REF;
         holdover   <= 1'b1;
         switch_evt <= 1'b0;
      end else begin
         active_idx <= idx_nxt;
         holdover   <= hold_nxt;
         switch_evt <= (idx_nxt != active_idx) || (hold_nxt != holdover);
      end
   end

   // ---------------- assertions ----------------
   a_r3_sticky_when_healthy: assert property (@(posedge clk) disable iff (!rst_n)
      (!ql_mode_q && !revert_q && cur_ok) |=> (active_idx == $past(active_idx)));

   a_r6_holdover_no_ref: assert property (@(posedge clk) disable iff (!rst_n)
      holdover |-> (active_idx == NO_REF));

   a_r6_valid_index: assert property (@(posedge clk) disable iff (!rst_n)
      !holdover |-> (active_idx < CAND_W'(NUM_CAND)));

   a_r8_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      ((active_idx != $past(active_idx)) || (holdover != $past(holdover))) |-> switch_evt);

   a_r8_quiet_when_stable: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(active_idx) && $stable(holdover)) |-> !switch_evt);

endmodule

// File: tb/clkref_selector_test.sv
module clkref_selector_test;
   import clkref_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  cand_ok = '0;
   logic [23:0] cand_ql = '0;
   logic [7:0]  prio_order = 8'hE4;
   logic [3:0]  prio_valid = 4'hF;
   logic        ql_sel_en = 1'b0;
   logic        revertive_en = 1'b1;
   logic [2:0]  active_idx;
   logic        holdover;
   logic        switch_evt;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   clkref_selector uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cand_ok      (cand_ok),
      .cand_ql      (cand_ql),
      .prio_order   (prio_order),
      .prio_valid   (prio_valid),
      .ql_sel_en    (ql_sel_en),
      .revertive_en (revertive_en),
      .active_idx   (active_idx),
      .holdover     (holdover),
      .switch_evt   (switch_evt)
   );

   typedef struct packed {
      logic [7:0]  ord;
      logic [3:0]  msk;
      logic [5:0]  ok;
      logic [23:0] ql;
      logic        qlm;
      logic        rev;
      logic [2:0]  idx;
      logic        hold;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{8'hE4, 4'hF, 6'h3F, 24'h000000, 1'b0, 1'b1, 3'd0, 1'b0},  // R1 top of list
      '{8'hE4, 4'hF, 6'h3E, 24'h000000, 1'b0, 1'b1, 3'd1, 1'b0},  // R1 standby follows active
      '{8'hE4, 4'hF, 6'h3C, 24'h000000, 1'b0, 1'b1, 3'd2, 1'b0},  // R2 next type
      '{8'h1B, 4'hF, 6'h3F, 24'h000000, 1'b0, 1'b1, 3'd4, 1'b0},  // R1 reversed order
      '{8'h1B, 4'hF, 6'h0F, 24'h000000, 1'b0, 1'b1, 3'd3, 1'b0},  // R2 pair failed
      '{8'hE4, 4'hE, 6'h3F, 24'h000000, 1'b0, 1'b1, 3'd2, 1'b0},  // R1 disabled slot
      '{8'hE4, 4'h1, 6'h3C, 24'h000000, 1'b0, 1'b1, 3'd7, 1'b1},  // R6 only unlisted ok
      '{8'h1A, 4'hF, 6'h3B, 24'h000000, 1'b0, 1'b1, 3'd3, 1'b0},  // R1 duplicate type
      '{8'hE4, 4'hF, 6'h3F, 24'h154532, 1'b1, 1'b1, 3'd2, 1'b0},  // R4 tie by rank
      '{8'h1B, 4'hF, 6'h3F, 24'h154532, 1'b1, 1'b1, 3'd4, 1'b0},  // R4 tie other order
      '{8'hE4, 4'hF, 6'h3B, 24'h154532, 1'b1, 1'b1, 3'd4, 1'b0},  // R4 best failed
      '{8'hE4, 4'hF, 6'h3F, 24'h154032, 1'b1, 1'b1, 3'd4, 1'b0},  // R5 code 0 dropped
      '{8'hE4, 4'hF, 6'h04, 24'h154032, 1'b1, 1'b1, 3'd7, 1'b1},  // R5 only DNU ok
      '{8'hE4, 4'hF, 6'h3F, 24'h000000, 1'b0, 1'b1, 3'd0, 1'b0},  // R5 codes ignored
      '{8'hE4, 4'hF, 6'h00, 24'h154532, 1'b1, 1'b1, 3'd7, 1'b1}   // R6 all failed
   };

   logic [2:0] prev_idx  = 3'd7;
   logic       prev_hold = 1'b1;

   task automatic check(input string req, input logic [2:0] e_idx,
                        input logic e_hold, input logic e_evt);
      total++;
      if (active_idx !== e_idx || holdover !== e_hold || switch_evt !== e_evt) begin
         bad++;
         $display("FAIL %s: idx=%0d hold=%0b evt=%0b expected idx=%0d hold=%0b evt=%0b",
                  req, active_idx, holdover, switch_evt, e_idx, e_hold, e_evt);
      end
   endtask

   // outputs settle two rising edges after an input change
   task automatic expect_after(input string req, input logic [2:0] e_idx, input logic e_hold);
      logic e_evt;
      repeat (2) @(negedge clk);
      e_evt = (e_idx != prev_idx) || (e_hold != prev_hold);
      check(req, e_idx, e_hold, e_evt);
      prev_idx  = e_idx;
      prev_hold = e_hold;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset", 3'd7, 1'b1, 1'b0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R9 idle after reset", 3'd7, 1'b1, 1'b0);

      for (int i = 0; i < NV; i++) begin
         prio_order   = VECS[i].ord;
         prio_valid   = VECS[i].msk;
         cand_ok      = VECS[i].ok;
         cand_ql      = VECS[i].ql;
         ql_sel_en    = VECS[i].qlm;
         revertive_en = VECS[i].rev;
         expect_after($sformatf("vector %0d", i), VECS[i].idx, VECS[i].hold);
      end

      // R3 non-revertive stickiness
      prio_order = 8'hE4; prio_valid = 4'hF; cand_ql = '0;
      ql_sel_en = 1'b0; revertive_en = 1'b0;
      cand_ok = 6'h04;
      expect_after("R7 leave holdover", 3'd2, 1'b0);
      cand_ok = 6'h3F;
      expect_after("R3 no revert on recovery", 3'd2, 1'b0);
      repeat (3) @(negedge clk);
      check("R3 still on current", 3'd2, 1'b0, 1'b0);
      cand_ok = 6'h3B;
      expect_after("R3 switch on failure", 3'd0, 1'b0);
      @(negedge clk);
      check("R8 pulse one cycle", 3'd0, 1'b0, 1'b0);

      // R7 holdover exit in non-revertive mode
      cand_ok = 6'h00;
      expect_after("R6 enter holdover", 3'd7, 1'b1);
      cand_ok = 6'h0C;
      expect_after("R7 best rank on exit", 3'd2, 1'b0);

      // R2 revertive return
      revertive_en = 1'b1;
      cand_ok = 6'h3E;
      expect_after("R2 move to better", 3'd1, 1'b0);
      cand_ok = 6'h3F;
      expect_after("R2 revert on recovery", 3'd0, 1'b0);

      // R4 quality mode ignores non-revertive setting; R9 latency
      ql_sel_en = 1'b1; revertive_en = 1'b0; cand_ql = 24'h154532;
      expect_after("R4 quality pick", 3'd2, 1'b0);
      cand_ql = 24'h157532;
      @(negedge clk);
      check("R9 unchanged after first edge", 3'd2, 1'b0, 1'b0);
      @(negedge clk);
      check("R4 quality overrides stickiness", 3'd3, 1'b1 ^ 1'b1, 1'b1);
      prev_idx = 3'd3; prev_hold = 1'b0;

      // R7 holdover exit in quality mode
      cand_ok = 6'h00;
      expect_after("R6 holdover in quality mode", 3'd7, 1'b1);
      cand_ok = 6'h3F; cand_ql = 24'h154532;
      expect_after("R7 best quality on exit", 3'd2, 1'b0);

      // R9 reset in operation
      rst_n = 1'b0;
      @(negedge clk);
      check("R9 reset mid-run", 3'd7, 1'b1, 1'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule